// File: doc/BRIEF.md
# USB Endpoint Stall and DMA Request Controller

This block is a register-mapped control unit for a USB function with four endpoints. It keeps one stall bit per endpoint and tells the protocol engine, when asked about an endpoint, whether that endpoint must answer the host with a STALL handshake. It also enforces two hardware rules that clear stall bits. A decoded setup request clears the control endpoint's stall bit. When auto-clear is enabled, the bit of any endpoint that has just completed a STALL transaction is cleared.

The same block drives the DMA request lines for two bulk endpoints. Each of these endpoints has a two-bank ping-pong FIFO. The OUT endpoint (EP1) asks for DMA service while either of its banks holds received data. The IN endpoint (EP2) asks for service while either of its banks is empty. The interrupt outputs for the same FIFO conditions are gated only by their own enable bits. Turning on DMA therefore does not silence them.

A CPU reaches four 32-bit registers over a simple single-cycle bus. Register reads are combinational on the address. Writes take effect at the clock edge when select and write are both high.

Top module: `usb_ep_stall_dma`

## Requirements
- R1: After reset every register reads 0, every stall output is 0, and both DMA requests and both interrupts are 0.
- R2: A write to offset 0x0 loads the stall bits from data bits 3..0 (bit n is endpoint n), and `stallOut` shows them from the next cycle. A read at 0x0 returns them in bits 3..0 with bits 31..4 reading 0.
- R3: `hsStall` equals the stall bit of the endpoint selected by `hsQueryEp`.
- R4: While `setupFlag` is 1, a write that carries 1 in bit 0 of offset 0x0 leaves the EP0 stall bit unchanged, and the other stall bits are still written. A write carrying 0 in bit 0 still clears the EP0 stall bit.
- R5: A `setupDecoded` pulse clears the EP0 stall bit on that edge, even if a CPU write sets it in the same cycle.
- R6: When control bit 0 (offset 0x8) is 1, a `stallDone` pulse clears the stall bit of endpoint `stallDoneEp` on that edge, and it wins over a same-cycle write. When control bit 0 is 0, `stallDone` has no effect.
- R7: `ep1DmaReq` is 1 exactly when DMA-enable bit 0 (offset 0x4) is 1 and at least one bit of `ep1BankFull` is 1.
- R8: `ep2DmaReq` is 1 exactly when DMA-enable bit 1 (offset 0x4) is 1 and at least one bit of `ep2BankEmpty` is 1.
- R9: `ep1FullIrq` equals interrupt-enable bit 0 (offset 0xC) ANDed with the OR of `ep1BankFull`. `ep2EmptyIrq` equals interrupt-enable bit 1 ANDed with the OR of `ep2BankEmpty`. Neither depends on the DMA enables.
- R10: A DMA request stays 0 while its enable bit is 0, whatever the bank states are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | Write strobe, qualified by busSel |
| busAddr | input | 4 | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr |
| setupFlag | input | 1 | Setup-received flag is pending |
| setupDecoded | input | 1 | Pulse: 8-byte setup request decoded by the function |
| stallDone | input | 1 | Pulse: a transaction that sent STALL has ended |
| stallDoneEp | input | 2 | Endpoint of that transaction |
| hsQueryEp | input | 2 | Endpoint being queried by the protocol engine |
| hsStall | output | 1 | Queried endpoint must answer STALL |
| stallOut | output | 4 | Stall state of every endpoint |
| ep1BankFull | input | 2 | Per-bank "holds data" flags of the EP1 FIFO |
| ep2BankEmpty | input | 2 | Per-bank "empty" flags of the EP2 FIFO |
| ep1DmaReq | output | 1 | DMA request for EP1 (OUT) |
| ep2DmaReq | output | 1 | DMA request for EP2 (IN) |
| ep1FullIrq | output | 1 | EP1 data-available interrupt |
| ep2EmptyIrq | output | 1 | EP2 space-available interrupt |

## Verification
The hardest situations to reach are collisions on a single clock edge. One case is a CPU write that sets a stall bit while a setup-decoded or STALL-done event clears that same bit. The other is a set of EP0 that arrives while the setup flag is pending. The bench produces these cases by driving the bus write and the event pulse in the same cycle. A behavioural model applies clear-over-write priority to predict the result. The DMA paths are swept through all four bank combinations, with the enable both off and on.

// File: rtl/usb_stall_pkg.sv
package usb_stall_pkg;
  localparam int REG_ADDR_W = 4;
  localparam logic [REG_ADDR_W-1:0] OFS_STALL = 4'h0;
  localparam logic [REG_ADDR_W-1:0] OFS_DMA   = 4'h4;
  localparam logic [REG_ADDR_W-1:0] OFS_CTRL  = 4'h8;
  localparam logic [REG_ADDR_W-1:0] OFS_IE    = 4'hC;

  // strobes from control to datapath
  typedef struct packed {
    logic wrStall;
    logic wrDma;
    logic wrCtrl;
    logic wrIe;
    logic ep0SetBlock;
  } regStrobe_t;
endpackage

// File: rtl/usb_stall_ctrl.sv
module usb_stall_ctrl
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 4,
  localparam int EP_IDX_W = $clog2(NUM_EP)
) (
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  setupFlag,
  input  logic                  setupDecoded,
  input  logic                  stallDone,
  input  logic [EP_IDX_W-1:0]   stallDoneEp,
  input  logic                  autoClrEn,
  output regStrobe_t            strobe,
  output logic [NUM_EP-1:0]     clrMask
);
  logic wrAccess;

  assign wrAccess = busSel && busWr;

  always_comb begin
    strobe             = '0;
    strobe.wrStall     = wrAccess && (busAddr == OFS_STALL);
    strobe.wrDma       = wrAccess && (busAddr == OFS_DMA);
    strobe.wrCtrl      = wrAccess && (busAddr == OFS_CTRL);
    strobe.wrIe        = wrAccess && (busAddr == OFS_IE);
    strobe.ep0SetBlock = setupFlag;
  end

  // clear requests per endpoint; these take priority in the datapath
  for (genvar i = 0; i < NUM_EP; i++) begin : g_clr
    logic autoHit;
    assign autoHit = stallDone && autoClrEn && (stallDoneEp == EP_IDX_W'(i));
    if (i == 0) begin : g_ep0
      assign clrMask[i] = autoHit || setupDecoded;
    end else begin : g_epn
      assign clrMask[i] = autoHit;
    end
  end
endmodule

// File: rtl/usb_stall_dp.sv
module usb_stall_dp
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 32,
  parameter int BANKS  = 2,
  localparam int EP_IDX_W = $clog2(NUM_EP)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  regStrobe_t            strobe,
  input  logic [NUM_EP-1:0]     clrMask,
  input  logic [NUM_EP-1:0]     wrBits,
  input  logic [REG_ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0]     busRdata,
  input  logic [EP_IDX_W-1:0]   hsQueryEp,
  output logic                  hsStall,
  output logic [NUM_EP-1:0]     stallOut,
  input  logic [BANKS-1:0]      ep1BankFull,
  input  logic [BANKS-1:0]      ep2BankEmpty,
  output logic                  ep1DmaReq,
  output logic                  ep2DmaReq,
  output logic                  ep1FullIrq,
  output logic                  ep2EmptyIrq,
  output logic                  autoClrEn
);
  logic [NUM_EP-1:0] stallQ;
  logic [1:0]        dmaEnQ;
  logic              ctrlQ;
  logic [1:0]        ieQ;
  logic              ep1HasData;
  logic              ep2HasRoom;

  for (genvar i = 0; i < NUM_EP; i++) begin : g_stall
    logic setBlocked;
    if (i == 0) begin : g_blk
      assign setBlocked = strobe.ep0SetBlock && wrBits[0];
    end else begin : g_noblk
      assign setBlocked = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rstN)                              stallQ[i] <= 1'b0;
      else if (clrMask[i])                    stallQ[i] <= 1'b0;
      else if (strobe.wrStall && !setBlocked) stallQ[i] <= wrBits[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaEnQ <= '0;
      ctrlQ  <= 1'b0;
      ieQ    <= '0;
    end else begin
      if (strobe.wrDma)  dmaEnQ <= wrBits[1:0];
      if (strobe.wrCtrl) ctrlQ  <= wrBits[0];
      if (strobe.wrIe)   ieQ    <= wrBits[1:0];
    end
  end

  assign ep1HasData  = |ep1BankFull;
  assign ep2HasRoom  = |ep2BankEmpty;
  assign ep1DmaReq   = dmaEnQ[0] && ep1HasData;
  assign ep2DmaReq   = dmaEnQ[1] && ep2HasRoom;
  assign ep1FullIrq  = ieQ[0] && ep1HasData;
  assign ep2EmptyIrq = ieQ[1] && ep2HasRoom;

  assign stallOut  = stallQ;
  assign hsStall   = stallQ[hsQueryEp];
  assign autoClrEn = ctrlQ;

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_STALL: busRdata[NUM_EP-1:0] = stallQ;
      OFS_DMA:   busRdata[1:0]        = dmaEnQ;
      OFS_CTRL:  busRdata[0]          = ctrlQ;
      OFS_IE:    busRdata[1:0]        = ieQ;
      default:   busRdata             = '0;
    endcase
  end
endmodule

// File: rtl/usb_ep_stall_dma.sv
module usb_ep_stall_dma
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int DATA_W = 32,
  parameter int BANKS  = 2,
  localparam int EP_IDX_W = $clog2(NUM_EP)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busSel,
  input  logic                  busWr,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0]     busWdata,
  output logic [DATA_W-1:0]     busRdata,
  input  logic                  setupFlag,
  input  logic                  setupDecoded,
  input  logic                  stallDone,
  input  logic [EP_IDX_W-1:0]   stallDoneEp,
  input  logic [EP_IDX_W-1:0]   hsQueryEp,
  output logic                  hsStall,
  output logic [NUM_EP-1:0]     stallOut,
  input  logic [BANKS-1:0]      ep1BankFull,
  input  logic [BANKS-1:0]      ep2BankEmpty,
  output logic                  ep1DmaReq,
  output logic                  ep2DmaReq,
  output logic                  ep1FullIrq,
  output logic                  ep2EmptyIrq
);
  regStrobe_t        strobe;
  logic [NUM_EP-1:0] clrMask;
  logic              autoClrEn;

  usb_stall_ctrl #(.NUM_EP(NUM_EP)) ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .setupFlag(setupFlag), .setupDecoded(setupDecoded),
    .stallDone(stallDone), .stallDoneEp(stallDoneEp),
    .autoClrEn(autoClrEn), .strobe(strobe), .clrMask(clrMask)
  );

  usb_stall_dp #(.NUM_EP(NUM_EP), .DATA_W(DATA_W), .BANKS(BANKS)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .clrMask(clrMask),
    .wrBits(busWdata[NUM_EP-1:0]), .busAddr(busAddr), .busRdata(busRdata),
    .hsQueryEp(hsQueryEp), .hsStall(hsStall), .stallOut(stallOut),
    .ep1BankFull(ep1BankFull), .ep2BankEmpty(ep2BankEmpty),
    .ep1DmaReq(ep1DmaReq), .ep2DmaReq(ep2DmaReq),
    .ep1FullIrq(ep1FullIrq), .ep2EmptyIrq(ep2EmptyIrq),
    .autoClrEn(autoClrEn)
  );
endmodule

// File: rtl/usb_ep_stall_dma_chk.sv
module usb_ep_stall_dma_chk
  import usb_stall_pkg::*;
#(
  parameter int NUM_EP = 4,
  parameter int BANKS  = 2,
  localparam int EP_IDX_W = $clog2(NUM_EP)
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busSel,
  input logic                  busWr,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic                  setupFlag,
  input logic                  setupDecoded,
  input logic                  stallDone,
  input logic [EP_IDX_W-1:0]   stallDoneEp,
  input logic [NUM_EP-1:0]     stallOut,
  input logic [BANKS-1:0]      ep1BankFull,
  input logic [BANKS-1:0]      ep2BankEmpty,
  input logic                  ep1DmaReq,
  input logic                  ep2DmaReq,
  input logic                  ep1FullIrq,
  input logic                  autoClrEn
);
  p_ep0_set_blocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && busWr && busAddr == OFS_STALL && setupFlag && !stallOut[0])
      |=> !stallOut[0]);

  p_decoded_clear_r5: assert property (@(posedge clk) disable iff (!rstN)
    setupDecoded |=> !stallOut[0]);

  p_auto_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stallDone && autoClrEn) |=> !stallOut[$past(stallDoneEp)]);

  p_ep1_req_needs_data_r7: assert property (@(posedge clk) disable iff (!rstN)
    ep1DmaReq |-> (|ep1BankFull));

  p_ep2_req_needs_room_r8: assert property (@(posedge clk) disable iff (!rstN)
    ep2DmaReq |-> (|ep2BankEmpty));

  p_irq_needs_data_r9: assert property (@(posedge clk) disable iff (!rstN)
    ep1FullIrq |-> (|ep1BankFull));
endmodule

bind usb_ep_stall_dma usb_ep_stall_dma_chk #(.NUM_EP(NUM_EP), .BANKS(BANKS)) chk (
  .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
  .setupFlag(setupFlag), .setupDecoded(setupDecoded), .stallDone(stallDone),
  .stallDoneEp(stallDoneEp), .stallOut(stallOut), .ep1BankFull(ep1BankFull),
  .ep2BankEmpty(ep2BankEmpty), .ep1DmaReq(ep1DmaReq), .ep2DmaReq(ep2DmaReq),
  .ep1FullIrq(ep1FullIrq), .autoClrEn(autoClrEn)
);

// File: tb/usb_ep_stall_dma_test.sv
module usb_ep_stall_dma_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [3:0]  busAddr = 4'h0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        setupFlag = 1'b0, setupDecoded = 1'b0, stallDone = 1'b0;
  logic [1:0]  stallDoneEp = 2'd0, hsQueryEp = 2'd0;
  logic        hsStall;
  logic [3:0]  stallOut;
  logic [1:0]  ep1BankFull = 2'b00, ep2BankEmpty = 2'b00;
  logic        ep1DmaReq, ep2DmaReq, ep1FullIrq, ep2EmptyIrq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  usb_ep_stall_dma uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .setupFlag(setupFlag),
    .setupDecoded(setupDecoded), .stallDone(stallDone), .stallDoneEp(stallDoneEp),
    .hsQueryEp(hsQueryEp), .hsStall(hsStall), .stallOut(stallOut),
    .ep1BankFull(ep1BankFull), .ep2BankEmpty(ep2BankEmpty),
    .ep1DmaReq(ep1DmaReq), .ep2DmaReq(ep2DmaReq),
    .ep1FullIrq(ep1FullIrq), .ep2EmptyIrq(ep2EmptyIrq)
  );

  // behavioural reference model
  bit mStall[4];
  bit mDma1, mDma2, mAuto, mIe1, mIe2;

  always @(posedge clk) begin
    bit oldAuto;
    oldAuto = mAuto;
    if (!rstN) begin
      foreach (mStall[k]) mStall[k] = 0;
      mDma1 = 0; mDma2 = 0; mAuto = 0; mIe1 = 0; mIe2 = 0;
    end else begin
      if (busSel && busWr) begin
        case (busAddr)
          4'h0: foreach (mStall[k])
                  if (!(k == 0 && setupFlag && busWdata[0])) mStall[k] = busWdata[k];
          4'h4: begin mDma1 = busWdata[0]; mDma2 = busWdata[1]; end
          4'h8: mAuto = busWdata[0];
          4'hC: begin mIe1 = busWdata[0]; mIe2 = busWdata[1]; end
          default: ;
        endcase
      end
      if (setupDecoded) mStall[0] = 0;
      if (stallDone && oldAuto) mStall[stallDoneEp] = 0;
    end
  end

  function automatic logic [3:0] mStallVec();
    return {mStall[3], mStall[2], mStall[1], mStall[0]};
  endfunction

  function automatic logic [31:0] mRead(input logic [3:0] a);
    case (a)
      4'h0: return {28'd0, mStallVec()};
      4'h4: return {30'd0, mDma2, mDma1};
      4'h8: return {31'd0, mAuto};
      4'hC: return {30'd0, mIe2, mIe1};
      default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) if (rstN) begin
    chk("R2 stallOut", {28'd0, stallOut}, {28'd0, mStallVec()});
    chk("R2 busRdata", busRdata, mRead(busAddr));
    chk("R3 hsStall", {31'd0, hsStall}, {31'd0, mStall[hsQueryEp]});
    chk("R7 ep1DmaReq", {31'd0, ep1DmaReq}, {31'd0, mDma1 && (ep1BankFull != 0)});
    chk("R8 ep2DmaReq", {31'd0, ep2DmaReq}, {31'd0, mDma2 && (ep2BankEmpty != 0)});
    chk("R9 ep1FullIrq", {31'd0, ep1FullIrq}, {31'd0, mIe1 && (ep1BankFull != 0)});
    chk("R9 ep2EmptyIrq", {31'd0, ep2EmptyIrq}, {31'd0, mIe2 && (ep2BankEmpty != 0)});
  end

  task automatic busWrite(input logic [3:0] a, input logic [31:0] d);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
  endtask

  task automatic readAt(input logic [3:0] a);
    busAddr = a;
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    ep2BankEmpty = 2'b11; ep1BankFull = 2'b11;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1 stallOut", {28'd0, stallOut}, 32'd0);
    chk("R1 dma reqs", {30'd0, ep1DmaReq, ep2DmaReq}, 32'd0);
    chk("R1 irqs", {30'd0, ep1FullIrq, ep2EmptyIrq}, 32'd0);
    for (int a = 0; a < 16; a += 4) begin
      readAt(4'(a));
      chk("R1 register", busRdata, 32'd0);
    end
    // R10: enables off, banks requesting
    chk("R10 requests idle", {30'd0, ep1DmaReq, ep2DmaReq}, 32'd0);

    // R2: stall write and reserved bits
    @(posedge clk); #1;
    busWrite(4'h0, 32'hFFFF_FFFF);
    readAt(4'h0);
    chk("R2 readback", busRdata, 32'h0000_000F);
    chk("R2 stallOut", {28'd0, stallOut}, 32'hF);
    // R3: query each endpoint
    @(posedge clk); #1;
    busWrite(4'h0, 32'h0000_0005);
    for (int e = 0; e < 4; e++) begin
      hsQueryEp = 2'(e);
      @(negedge clk);
      chk("R3 query", {31'd0, hsStall}, {31'd0, (e == 0 || e == 2) ? 1'b1 : 1'b0});
      @(posedge clk); #1;
    end

    // R4: setup flag pending blocks setting EP0
    busWrite(4'h0, 32'h0);
    setupFlag = 1'b1;
    busWrite(4'h0, 32'h1);
    @(negedge clk);
    chk("R4 ep0 set ignored", {28'd0, stallOut}, 32'h0);
    @(posedge clk); #1;
    busWrite(4'h0, 32'h3);
    @(negedge clk);
    chk("R4 others written", {28'd0, stallOut}, 32'h2);
    @(posedge clk); #1;
    setupFlag = 1'b0;
    busWrite(4'h0, 32'h1);
    setupFlag = 1'b1;
    busWrite(4'h0, 32'h0);
    @(negedge clk);
    chk("R4 ep0 clear allowed", {28'd0, stallOut}, 32'h0);
    @(posedge clk); #1;
    setupFlag = 1'b0;

    // R5: decoded setup clears EP0, also against same-cycle write
    busWrite(4'h0, 32'h3);
    setupDecoded = 1'b1;
    @(posedge clk); #1;
    setupDecoded = 1'b0;
    @(negedge clk);
    chk("R5 decoded clear", {28'd0, stallOut}, 32'h2);
    @(posedge clk); #1;
    setupDecoded = 1'b1;
    busWrite(4'h0, 32'h1);
    setupDecoded = 1'b0;
    @(negedge clk);
    chk("R5 clear beats write", {28'd0, stallOut}, 32'h0);
    @(posedge clk); #1;

    // R6: auto clear only when enabled
    busWrite(4'h0, 32'hF);
    stallDone = 1'b1; stallDoneEp = 2'd2;
    @(posedge clk); #1;
    stallDone = 1'b0;
    @(negedge clk);
    chk("R6 disabled no effect", {28'd0, stallOut}, 32'hF);
    @(posedge clk); #1;
    busWrite(4'h8, 32'h1);
    stallDone = 1'b1; stallDoneEp = 2'd2;
    @(posedge clk); #1;
    stallDone = 1'b0;
    @(negedge clk);
    chk("R6 auto clear ep2", {28'd0, stallOut}, 32'hB);
    @(posedge clk); #1;
    stallDone = 1'b1; stallDoneEp = 2'd3;
    busWrite(4'h0, 32'hF);
    stallDone = 1'b0;
    @(negedge clk);
    chk("R6 clear beats write", {28'd0, stallOut}, 32'h7);
    @(posedge clk); #1;

    // R10: enables off, sweep banks
    for (int c = 0; c < 4; c++) begin
      ep1BankFull = 2'(c); ep2BankEmpty = 2'(c);
      @(negedge clk);
      chk("R10 held low", {30'd0, ep1DmaReq, ep2DmaReq}, 32'd0);
      @(posedge clk); #1;
    end
    // R7 R8: enables on, all bank combinations
    busWrite(4'h4, 32'h3);
    for (int c = 0; c < 4; c++) begin
      ep1BankFull = 2'(c); ep2BankEmpty = 2'(3 - c);
      @(negedge clk);
      chk("R7 ep1 req", {31'd0, ep1DmaReq}, {31'd0, c != 0});
      chk("R8 ep2 req", {31'd0, ep2DmaReq}, {31'd0, c != 3});
      @(posedge clk); #1;
    end
    // R9: interrupts independent of DMA enables
    for (int ie = 0; ie < 4; ie++) begin
      busWrite(4'hC, 32'(ie));
      for (int c = 0; c < 4; c++) begin
        ep1BankFull = 2'(c); ep2BankEmpty = 2'(c);
        @(negedge clk);
        chk("R9 irq1", {31'd0, ep1FullIrq}, {31'd0, ie[0] && c != 0});
        chk("R9 irq2", {31'd0, ep2EmptyIrq}, {31'd0, ie[1] && c != 0});
        @(posedge clk); #1;
      end
    end

    repeat (4) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule